// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is the digital side of a serial EEPROM reached over three wires: a chip select, a serial clock and a data input, with one data output. It stores words of 16 bits in a plain register array addressed by a parameterised 10 to 12 bit address. The host frames every command as a 1 start bit, a 2-bit opcode and an address, all sent MSB first. The block then either streams words back, takes a data word in and programs it, or changes its write lock.

All three host wires are resynchronised into the system clock, and the rising edges of the serial clock are detected there. Programming is self-timed by a counter of system clock cycles. During that time the output pin reports busy (0), and afterwards it reports ready (1). The status stays on the pin, whenever select is high, until the host clocks in the start bit of its next command. The output has a separate enable, so the pad tristate sits outside the block.

There is no flow-controlled data stream here. The host paces every bit with its own serial clock, so all ports are plain control and data pins with no back-pressure.

Top module: `tri_wire_eeprom`

## Requirements
- R1: A command is a start bit of 1, a 2-bit opcode and ADDR_W address bits, all sampled MSB first on serial clock rising edges. Opcode 2'b10 is read, 2'b01 is write and 2'b00 is special. For a special command the two address MSBs select the action: 2'b11 unlocks writes, 2'b00 locks writes and 2'b01 writes all words.
- R2: Any number of 0 bits before the start bit is ignored. A command sent as 001... acts the same as one sent as 1...
- R3: Reset clears the write latch and sets every word to 0. While the latch is clear, write and write-all change no word and start no programming. The lock command clears the latch again.
- R4: A read drives a single 0 on the output at the edge that takes the last address bit. The following 16 edges drive the addressed word MSB first. Reads work whatever the latch state.
- R5: If the serial clock continues after the 16th data bit, the next word follows with no dummy bit. The address wraps from 2**ADDR_W-1 to 0.
- R6: A write takes 16 data bits MSB first after the address. Programming starts at the edge that takes the last data bit, and the addressed word then holds the new value.
- R7: While select is high, the output drives 0 for PROG_CYCLES system cycles after programming starts and then drives 1. It keeps driving 1 across select toggles until a start bit is clocked in.
- R8: The output enable is 0 whenever select is low, and also whenever neither read data nor status is being shown (for example after an unlock command).
- R9: A command whose start bit arrives while programming is in progress is ignored entirely, and the status display is dropped.
- R10: A write cut off by select falling before its 16th data bit changes no word and starts no programming.
- R11: Write-all, when unlocked, loads the data word into every location within a single programming period of PROG_CYCLES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_i | input | 1 | Chip select, active high, asynchronous to clk |
| sck_i | input | 1 | Serial clock from the host, asynchronous to clk |
| din_i | input | 1 | Serial data from the host |
| dout_o | output | 1 | Serial data or busy/ready status |
| dout_oe_o | output | 1 | Output enable for dout_o; 0 means high impedance |

## Verification
A wrong write latch shows up at the edge that takes the last data bit of the next write. A locked part that wrongly programs drives busy there, and an unlocked part that fails to program does not, so the error appears within one command. A bad data shift register or read address counter is seen at the first read of that word, or at the 17th bit of a streamed read for the increment and wrap path. A timer fault shows up as a busy window whose length is off from PROG_CYCLES, measured on the pin while select is held high. A status flag that is not cleared shows up as the output still being enabled one bit after the next start bit.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } fr_state_t;

  localparam logic [1:0] OP_SPEC  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  localparam logic [1:0] SP_LOCK   = 2'b00;
  localparam logic [1:0] SP_FILL   = 2'b01;
  localparam logic [1:0] SP_UNLOCK = 2'b11;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], raw[i]};
      end
      assign lvl[i] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/eep_timer.sv
module eep_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int TW = $clog2(CYCLES + 1);
  localparam logic [TW-1:0] LOAD = TW'(CYCLES);

  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (start)           remain <= LOAD;
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          fill,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      if (fill) begin
        for (int i = 0; i < DEPTH; i++) cells[i] <= wdata;
      end else begin
        cells[waddr] <= wdata;
      end
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eep_frame.sv
module eep_frame
  import eep_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          sck_rise,
  input  logic          din,
  input  logic          busy,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic          prog_start,
  output logic          prog_fill,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output logic          wen_latch,
  output logic          dout,
  output logic          dout_oe
);
  localparam int ACW = $clog2(AW);
  localparam int BCW = $clog2(DW);
  localparam logic [ACW-1:0] A_LAST = ACW'(AW - 1);
  localparam logic [ACW-1:0] O_LAST = ACW'(1);

  fr_state_t      state;
  logic [1:0]     op;
  logic [AW-1:0]  sh_addr;
  logic [DW-1:0]  sh_data;
  logic [ACW-1:0] acnt;
  logic [BCW-1:0] bcnt;
  logic           fill_q;
  logic           stat_show;
  logic           out_bit;

  logic [AW-1:0] addr_nx;
  logic [DW-1:0] data_nx;
  logic [1:0]    spec;

  assign addr_nx = {sh_addr[AW-2:0], din};
  assign data_nx = {sh_data[DW-2:0], din};
  assign spec    = addr_nx[AW-1 -: 2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      op         <= '0;
      sh_addr    <= '0;
      sh_data    <= '0;
      acnt       <= '0;
      bcnt       <= '0;
      fill_q     <= 1'b0;
      stat_show  <= 1'b0;
      out_bit    <= 1'b0;
      raddr      <= '0;
      prog_start <= 1'b0;
      prog_fill  <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
      wen_latch  <= 1'b0;
    end else begin
      prog_start <= 1'b0;
      if (!cs) begin
        state <= ST_IDLE;
        acnt  <= '0;
        bcnt  <= '0;
      end else if (sck_rise) begin
        unique case (state)
          ST_IDLE: begin
            if (din) begin
              stat_show <= 1'b0;
              acnt      <= '0;
              state     <= busy ? ST_SKIP : ST_OPC;
            end
          end
          ST_OPC: begin
            op <= {op[0], din};
            if (acnt == O_LAST) begin
              acnt  <= '0;
              state <= ST_ADDR;
            end else begin
              acnt <= acnt + 1'b1;
            end
          end
          ST_ADDR: begin
            sh_addr <= addr_nx;
            if (acnt == A_LAST) begin
              acnt  <= '0;
              bcnt  <= '0;
              state <= ST_SKIP;
              unique case (op)
                OP_READ: begin
                  state   <= ST_RDATA;
                  raddr   <= addr_nx;
                  out_bit <= 1'b0;
                end
                OP_WRITE: begin
                  if (wen_latch) begin
                    state  <= ST_WDATA;
                    fill_q <= 1'b0;
                  end
                end
                OP_SPEC: begin
                  unique case (spec)
                    SP_UNLOCK: wen_latch <= 1'b1;
                    SP_LOCK:   wen_latch <= 1'b0;
                    SP_FILL: begin
                      if (wen_latch) begin
                        state  <= ST_WDATA;
                        fill_q <= 1'b1;
                      end
                    end
                    default: ;
                  endcase
                end
                default: ;
              endcase
            end else begin
              acnt <= acnt + 1'b1;
            end
          end
          ST_WDATA: begin
            sh_data <= data_nx;
            bcnt    <= bcnt + 1'b1;
            if (bcnt == '1) begin
              prog_start <= 1'b1;
              prog_fill  <= fill_q;
              prog_addr  <= sh_addr;
              prog_data  <= data_nx;
              stat_show  <= 1'b1;
              state      <= ST_SKIP;
            end
          end
          ST_RDATA: begin
            out_bit <= rdata[~bcnt];
            bcnt    <= bcnt + 1'b1;
            if (bcnt == '1) raddr <= raddr + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign dout_oe = cs & ((state == ST_RDATA) | stat_show);
  assign dout    = (state == ST_RDATA) ? out_bit : ~(busy | prog_start);
endmodule

// File: rtl/tri_wire_eeprom.sv
module tri_wire_eeprom #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sck_i,
  input  logic din_i,
  output logic dout_o,
  output logic dout_oe_o
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] raw_in;
  logic [NSIG-1:0] sync_lvl;
  logic            cs_s;
  logic            sck_s;
  logic            din_s;
  logic            sck_d;
  logic            sck_rise;

  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] rdata;
  logic              prog_start;
  logic              prog_fill;
  logic [ADDR_W-1:0] prog_addr;
  logic [DATA_W-1:0] prog_data;
  logic              wen_latch;
  logic              busy;

  assign raw_in = {din_i, sck_i, cs_i};
  assign cs_s   = sync_lvl[0];
  assign sck_s  = sync_lvl[1];
  assign din_s  = sync_lvl[2];

  eep_sync #(.N(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (raw_in),
    .lvl   (sync_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end
  assign sck_rise = sck_s & ~sck_d;

  eep_frame #(.AW(ADDR_W), .DW(DATA_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs         (cs_s),
    .sck_rise   (sck_rise),
    .din        (din_s),
    .busy       (busy),
    .rdata      (rdata),
    .raddr      (raddr),
    .prog_start (prog_start),
    .prog_fill  (prog_fill),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .wen_latch  (wen_latch),
    .dout       (dout_o),
    .dout_oe    (dout_oe_o)
  );

  eep_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (prog_start),
    .busy  (busy)
  );

  eep_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (prog_start),
    .fill  (prog_fill),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (raddr),
    .rdata (rdata)
  );
endmodule

// File: rtl/eep_chk.sv
module eep_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic busy,
  input logic prog_start,
  input logic wen_latch,
  input logic dout_o,
  input logic dout_oe_o
);
  AST_PROG_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> wen_latch); // R3

  AST_NO_PROG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !busy); // R9

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> busy); // R7

  AST_BUSY_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dout_oe_o) |-> !dout_o); // R7

  AST_HIZ_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |-> !dout_oe_o); // R8
endmodule

bind tri_wire_eeprom eep_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_s       (cs_s),
  .busy       (busy),
  .prog_start (prog_start),
  .wen_latch  (wen_latch),
  .dout_o     (dout_o),
  .dout_oe_o  (dout_oe_o)
);

// File: tb/test_tri_wire_eeprom.sv
module test_tri_wire_eeprom;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 10;
  localparam int DW    = 16;
  localparam int PROG  = 60;
  localparam int HALF  = 5;
  localparam int DEPTH = 1 << AW;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sck = 1'b0;
  logic din = 1'b0;
  logic dout;
  logic dout_oe;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #(CLK_PERIOD / 2) clk = ~clk;

  tri_wire_eeprom #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG)) i_tri_wire_eeprom (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_i      (cs),
    .sck_i     (sck),
    .din_i     (din),
    .dout_o    (dout),
    .dout_oe_o (dout_oe)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, LIMIT);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_up();
    cs = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic cs_down();
    cs = 1'b0;
    sck = 1'b0;
    wait_clk(2 * HALF);
  endtask

  task automatic sk_bit(input logic b, output logic dv, output logic ov);
    din = b;
    wait_clk(HALF);
    sck = 1'b1;
    wait_clk(HALF);
    dv = dout;
    ov = dout_oe;
    sck = 1'b0;
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [AW-1:0] a,
                          output logic dv, output logic ov);
    sk_bit(1'b1, dv, ov);
    sk_bit(op[1], dv, ov);
    sk_bit(op[0], dv, ov);
    for (int i = AW - 1; i >= 0; i--) sk_bit(a[i], dv, ov);
  endtask

  task automatic send_word(input logic [DW-1:0] d, input int nbits,
                           output logic dv, output logic ov);
    for (int i = DW - 1; i >= DW - nbits; i--) sk_bit(d[i], dv, ov);
  endtask

  // CS stays high after the last data bit; count cycles until ready shows.
  task automatic wait_ready(input string req);
    int cnt;
    logic ok;
    cnt = 0;
    while (dout !== 1'b1 && cnt < 4 * PROG) begin
      @(negedge clk);
      cnt++;
    end
    ok = (cnt >= PROG - 3) && (cnt <= PROG + 1);
    chk({req, " busy window length"}, {31'd0, ok}, 32'd1);
    chk({req, " ready enabled"}, {31'd0, dout_oe}, 32'd1);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic lead0);
    logic dv, ov, x;
    cs_up();
    if (lead0) begin
      sk_bit(1'b0, dv, x);
      sk_bit(1'b0, dv, x);
    end
    send_cmd(2'b01, a, dv, ov);
    send_word(d, DW, dv, ov);
    chk("R6 busy at last data bit", {30'd0, ov, dv}, 32'h2);
    wait_ready("R7");
    cs_down();
    cs_up();
    chk("R7 ready held after select toggle", {30'd0, dout_oe, dout}, 32'h3);
    cs_down();
    ref_mem[a] = d;
  endtask

  task automatic try_locked_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic dv, ov;
    cs_up();
    send_cmd(2'b01, a, dv, ov);
    send_word(d, DW, dv, ov);
    chk("R3 locked write shows no status", {31'd0, ov}, 32'd0);
    cs_down();
  endtask

  task automatic special(input logic [1:0] sp, input string req);
    logic dv, ov;
    cs_up();
    send_cmd(2'b00, {sp, {(AW-2){1'b0}}}, dv, ov);
    chk({req, " special leaves output off"}, {31'd0, ov}, 32'd0);
    cs_down();
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int nw, input string req);
    logic dv, ov;
    logic [DW-1:0] w;
    logic [AW-1:0] ea;
    cs_up();
    send_cmd(2'b10, a, dv, ov);
    chk({req, " dummy bit"}, {30'd0, ov, dv}, 32'h2);
    for (int k = 0; k < nw; k++) begin
      for (int i = DW - 1; i >= 0; i--) begin
        sk_bit(1'b0, dv, ov);
        w[i] = dv;
      end
      ea = a + AW'(k);
      chk({req, " read word"}, {16'd0, w}, {16'd0, ref_mem[ea]});
    end
    cs_down();
  endtask

  initial begin
    logic dv, ov;
    logic [DW-1:0] d;
    logic [AW-1:0] a;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    wait_clk(5);
    chk("R8 reset output disabled", {31'd0, dout_oe}, 32'd0);
    rst_n = 1'b1;
    wait_clk(5);
    chk("R8 idle output disabled", {31'd0, dout_oe}, 32'd0);

    // R3 / R4: reset contents zero, read works while locked.
    do_read(10'd5, 1, "R4 locked read");
    try_locked_write(10'd5, 16'hA5C3);
    do_read(10'd5, 1, "R3 locked write ignored");

    special(2'b11, "R1 unlock");

    // R6: sweep of addresses and data patterns, computed arithmetically.
    for (int i = 0; i < 10; i++) begin
      a = AW'((i * 97 + 3) % DEPTH);
      d = DW'((i * 16'h1357) ^ 16'hA5A5);
      do_write(a, d, 1'b0);
    end
    for (int i = 0; i < 10; i++) begin
      a = AW'((i * 97 + 3) % DEPTH);
      do_read(a, 1, "R6 write/readback");
    end

    // R2: leading zeros before the start bit.
    do_write(10'd1022, 16'h8001, 1'b1);
    do_write(10'd1023, 16'h7FFE, 1'b1);
    do_write(10'd0,    16'h0F0F, 1'b0);
    do_write(10'd1,    16'hF00F, 1'b0);
    do_read(10'd1022, 1, "R2 leading zeros");

    // R5: streamed read across the top of the address space.
    do_read(10'd1022, 4, "R5 wrap stream");

    // R9: command arriving while busy is ignored; R8 off while deselected.
    cs_up();
    send_cmd(2'b01, 10'd200, dv, ov);
    send_word(16'h1234, DW, dv, ov);
    ref_mem[200] = 16'h1234;
    cs = 1'b0;
    wait_clk(2 * HALF);
    chk("R8 deselected during busy", {31'd0, dout_oe}, 32'd0);
    cs_up();
    chk("R7 busy after reselect", {30'd0, dout_oe, dout}, 32'h2);
    send_cmd(2'b01, 10'd300, dv, ov);
    chk("R9 status dropped after start", {31'd0, ov}, 32'd0);
    send_word(16'hDEAD, DW, dv, ov);
    chk("R9 ignored write shows nothing", {31'd0, ov}, 32'd0);
    cs_down();
    wait_clk(2 * PROG);
    do_read(10'd300, 1, "R9 ignored write");
    do_read(10'd200, 1, "R9 write before busy");

    // R7: start bit clears the held ready status.
    cs_up();
    sk_bit(1'b1, dv, ov);
    chk("R7 start bit drops status", {31'd0, ov}, 32'd0);
    cs_down();

    // R10: aborted write.
    cs_up();
    send_cmd(2'b01, 10'd3, dv, ov);
    send_word(16'hBEEF, 8, dv, ov);
    cs_down();
    cs_up();
    chk("R10 abort starts no programming", {31'd0, dout_oe}, 32'd0);
    cs_down();
    do_read(10'd3, 1, "R10 aborted write");

    // R3: lock again, writes and write-all ignored.
    special(2'b00, "R3 lock");
    try_locked_write(10'd0, 16'h5555);
    cs_up();
    send_cmd(2'b00, {2'b01, {(AW-2){1'b0}}}, dv, ov);
    send_word(16'h5555, DW, dv, ov);
    chk("R3 locked fill shows no status", {31'd0, ov}, 32'd0);
    cs_down();
    do_read(10'd0, 2, "R3 locked fill ignored");

    // R11: write-all when unlocked, one programming period.
    special(2'b11, "R1 unlock again");
    cs_up();
    send_cmd(2'b00, {2'b01, {(AW-2){1'b0}}}, dv, ov);
    send_word(16'h3C5A, DW, dv, ov);
    chk("R11 fill busy", {30'd0, ov, dv}, 32'h2);
    wait_ready("R11");
    cs_down();
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'h3C5A;
    do_read(10'd1023, 3, "R11 fill stream");
    do_read(10'd517, 1, "R11 fill middle");
    do_read(10'd300, 1, "R11 fill former");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule